// File: doc/BRIEF.md
# NOR Flash Bank Command Mode Controller

This block is the command-register state machine of a single bank in a NOR-style flash array. Each write cycle on the bus carries an address and a data byte. The block decodes these cycles into unlock sequences and commands. It then tracks which mode the bank is in: plain array read, identifier read, a program or erase run by the embedded algorithm engine, erase suspended with reads allowed, or a program issued while an erase is suspended. Two further modes cover a failed operation and a malformed sequence.

For the embedded algorithm engine, the block raises a single-cycle start pulse for a program or for a sector erase. The engine reports back through a done input and a fail input. For the read path, the block produces a select that picks array data, status data or identifier data. While an erase is suspended, that select depends on the sector being read. The suspended sector returns status, and every other sector returns array data.

The reset command (0xF0) has a target that depends on context. It returns the bank to array read, or to suspended-erase read when an erase is suspended. While an embedded operation runs, the reset command has no effect.

Top module: `nbc_bank_ctrl`

## Requirements
- R1: After reset is released, `mode_o` is 0 (array read), `rd_sel_o` is 0 (array), `fail_flag_o` is 0, and neither start pulse is high.
- R2: The program command is a write of 0xAA at low address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555. The next write that is not 0xF0 then raises `prog_start_o` for one cycle, and `mode_o` becomes 2 (program busy).
- R3: The sector erase command has six cycles: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address. This raises `erase_start_o` for one cycle, sets `mode_o` to 3 (erase busy), and records the sector, which is the top SECT_W bits of the address.
- R4: A write of data 0xF0 at any address part-way through a sequence aborts it. No start pulse follows, and `mode_o` stays at 0, or at 4 if an erase is suspended.
- R5: In modes 2, 3 and 5 (a busy operation), a 0xF0 write leaves `mode_o` unchanged.
- R6: A third cycle of 0x90@0x555 enters identifier mode. In this mode `mode_o` is 1 and `rd_sel_o` is 2 (ID). Only a 0xF0 write leaves this mode. It returns to mode 0, or to mode 4 if the bank entered from suspend.
- R7: A write of 0xB0 in mode 3 suspends the erase and gives mode 4. In mode 4, `rd_sel_o` is 1 (status) when `rd_sect_i` equals the recorded sector, and 0 otherwise. A 0x30 write outside a sequence in mode 4 resumes the erase and gives mode 3.
- R8: A program command given in mode 4 leads to mode 5. A done in mode 5 returns the bank to mode 4, and the suspended sector still reads as status.
- R9: `alg_done_i` in mode 2 or 3 returns the bank to mode 0.
- R10: `alg_fail_i` in a busy mode gives mode 6. In mode 6, `fail_flag_o` is 1 and `rd_sel_o` is 1. The bank stays in mode 6 until a 0xF0 write, which returns it to mode 0, or to mode 4 if the failed program was issued in suspend.
- R11: A wrong address or wrong data in cycles 2 to 6 of a sequence gives mode 7 (lockout) with `rd_sel_o` at 1. Only a 0xF0 write clears it. A write outside a sequence that is neither an unlock nor a reset is ignored.
- R12: `rd_sel_o` is 0 in mode 0. It is 1 in modes 2, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Write strobe, one cycle per bus write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | 8 | Write data byte |
| rd_sect_i | input | SECT_W | Sector of the current read address |
| alg_done_i | input | 1 | Embedded algorithm completed |
| alg_fail_i | input | 1 | Embedded algorithm failed |
| mode_o | output | 3 | Bank mode code |
| rd_sel_o | output | 2 | Read data select: 0 array, 1 status, 2 ID |
| prog_start_o | output | 1 | One-cycle program start pulse |
| erase_start_o | output | 1 | One-cycle sector erase start pulse |
| fail_flag_o | output | 1 | Operation failure flag, the DQ5 equivalent |

## Verification
A write, done or fail presented at a rising edge changes `mode_o`, the start pulses and `fail_flag_o` right after that edge. `rd_sel_o` follows the registered mode and `rd_sect_i` with no extra register. Two further edges pass after `rst_n` rises before the internal reset lifts. The bench drives every input on a falling edge and samples on the next falling edge. This places each check one cycle after its stimulus. Each pulse is also checked low one cycle later.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  typedef enum logic [2:0] {
    M_READ    = 3'd0,
    M_AUTOSEL = 3'd1,
    M_PROG    = 3'd2,
    M_ERASE   = 3'd3,
    M_SUSP    = 3'd4,
    M_SPROG   = 3'd5,
    M_FAULT   = 3'd6,
    M_LOCK    = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    RS_ARRAY  = 2'd0,
    RS_STATUS = 2'd1,
    RS_ID     = 2'd2
  } rsel_e;

  typedef enum logic [2:0] {
    Q_IDLE = 3'd0,
    Q_U1   = 3'd1,
    Q_U2   = 3'd2,
    Q_PSET = 3'd3,
    Q_E1   = 3'd4,
    Q_E2   = 3'd5,
    Q_E3   = 3'd6
  } seq_e;

  // classification of one write cycle
  typedef struct packed {
    logic unl1;     // first unlock byte at its address
    logic unl2;     // second unlock byte at its address
    logic at_cmd;   // low address is the command address
    logic reset;
    logic prog;
    logic setup;
    logic autosel;
    logic suspend;
    logic go;       // erase confirm / resume byte
  } wcls_t;

  localparam logic [7:0] D_UNL1    = 8'hAA;
  localparam logic [7:0] D_UNL2    = 8'h55;
  localparam logic [7:0] D_PROG    = 8'hA0;
  localparam logic [7:0] D_SETUP   = 8'h80;
  localparam logic [7:0] D_AUTOSEL = 8'h90;
  localparam logic [7:0] D_RESET   = 8'hF0;
  localparam logic [7:0] D_SUSPEND = 8'hB0;
  localparam logic [7:0] D_GO      = 8'h30;

endpackage

// File: rtl/nbc_decode.sv
module nbc_decode
  import nbc_pkg::*;
#(
  parameter int LOW_W = 12
) (
  input  logic [LOW_W-1:0] lo_addr_i,
  input  logic [7:0]       data_i,
  output wcls_t            cls_o
);
  localparam logic [LOW_W-1:0] A_CMD = LOW_W'(12'h555);
  localparam logic [LOW_W-1:0] A_ALT = LOW_W'(12'h2AA);

  always_comb begin
    cls_o.at_cmd  = (lo_addr_i == A_CMD);
    cls_o.unl1    = (lo_addr_i == A_CMD) && (data_i == D_UNL1);
    cls_o.unl2    = (lo_addr_i == A_ALT) && (data_i == D_UNL2);
    cls_o.reset   = (data_i == D_RESET);
    cls_o.prog    = (data_i == D_PROG);
    cls_o.setup   = (data_i == D_SETUP);
    cls_o.autosel = (data_i == D_AUTOSEL);
    cls_o.suspend = (data_i == D_SUSPEND);
    cls_o.go      = (data_i == D_GO);
  end
endmodule

// File: rtl/nbc_fsm.sv
module nbc_fsm
  import nbc_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  wcls_t             cls_i,
  input  logic [SECT_W-1:0] wr_sect_i,
  input  logic              alg_done_i,
  input  logic              alg_fail_i,
  output mode_e             mode_o,
  output logic [SECT_W-1:0] sect_o,
  output logic              prog_start_o,
  output logic              erase_start_o
);
  mode_e             mode_q, mode_d, ret_mode;
  seq_e              seq_q, seq_d;
  logic              susp_q, susp_d;
  logic [SECT_W-1:0] sect_q;
  logic              sect_en, ps_d, es_d, ps_q, es_q, bad;

  // next-state process
  always_comb begin
    mode_d   = mode_q;
    seq_d    = seq_q;
    susp_d   = susp_q;
    sect_en  = 1'b0;
    ps_d     = 1'b0;
    es_d     = 1'b0;
    bad      = 1'b0;
    ret_mode = susp_q ? M_SUSP : M_READ;
    case (mode_q)
      M_READ, M_SUSP: begin
        if (wr_en_i) begin
          if (cls_i.reset) begin
            seq_d = Q_IDLE;
          end else begin
            case (seq_q)
              Q_IDLE: begin
                if (cls_i.unl1) seq_d = Q_U1;
                else if (susp_q && cls_i.go) begin
                  mode_d = M_ERASE;
                  susp_d = 1'b0;
                end
              end
              Q_U1: if (cls_i.unl2) seq_d = Q_U2; else bad = 1'b1;
              Q_U2: begin
                if (cls_i.at_cmd && cls_i.prog) seq_d = Q_PSET;
                else if (cls_i.at_cmd && cls_i.autosel) begin
                  mode_d = M_AUTOSEL;
                  seq_d  = Q_IDLE;
                end else if (cls_i.at_cmd && cls_i.setup && !susp_q) seq_d = Q_E1;
                else bad = 1'b1;
              end
              Q_PSET: begin
                ps_d   = 1'b1;
                mode_d = susp_q ? M_SPROG : M_PROG;
                seq_d  = Q_IDLE;
              end
              Q_E1: if (cls_i.unl1) seq_d = Q_E2; else bad = 1'b1;
              Q_E2: if (cls_i.unl2) seq_d = Q_E3; else bad = 1'b1;
              Q_E3: begin
                if (cls_i.go) begin
                  es_d    = 1'b1;
                  sect_en = 1'b1;
                  mode_d  = M_ERASE;
                  seq_d   = Q_IDLE;
                end else bad = 1'b1;
              end
              default: seq_d = Q_IDLE;
            endcase
            if (bad) begin
              mode_d = M_LOCK;
              seq_d  = Q_IDLE;
            end
          end
        end
      end
      M_AUTOSEL, M_LOCK, M_FAULT: begin
        if (wr_en_i && cls_i.reset) mode_d = ret_mode;
      end
      M_PROG, M_ERASE, M_SPROG: begin
        if (alg_fail_i) mode_d = M_FAULT;
        else if (alg_done_i) mode_d = (mode_q == M_SPROG) ? M_SUSP : M_READ;
        else if (mode_q == M_ERASE && wr_en_i && cls_i.suspend) begin
          mode_d = M_SUSP;
          susp_d = 1'b1;
        end
      end
      default: mode_d = M_READ;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_READ;
      seq_q  <= Q_IDLE;
      susp_q <= 1'b0;
      ps_q   <= 1'b0;
      es_q   <= 1'b0;
      sect_q <= '0;
    end else begin
      mode_q <= mode_d;
      seq_q  <= seq_d;
      susp_q <= susp_d;
      ps_q   <= ps_d;
      es_q   <= es_d;
      if (sect_en) sect_q <= wr_sect_i;
    end
  end

  assign mode_o        = mode_q;
  assign sect_o        = sect_q;
  assign prog_start_o  = ps_q;
  assign erase_start_o = es_q;
endmodule

// File: rtl/nbc_rdsel.sv
module nbc_rdsel
  import nbc_pkg::*;
#(
  parameter int SECT_W = 4
) (
  input  mode_e             mode_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  input  logic [SECT_W-1:0] susp_sect_i,
  output rsel_e             sel_o
);
  always_comb begin
    case (mode_i)
      M_READ:    sel_o = RS_ARRAY;
      M_AUTOSEL: sel_o = RS_ID;
      M_SUSP:    sel_o = (rd_sect_i == susp_sect_i) ? RS_STATUS : RS_ARRAY;
      default:   sel_o = RS_STATUS;
    endcase
  end
endmodule

// File: rtl/nbc_bank_ctrl.sv
module nbc_bank_ctrl
  import nbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  input  logic              alg_done_i,
  input  logic              alg_fail_i,
  output logic [2:0]        mode_o,
  output logic [1:0]        rd_sel_o,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic              fail_flag_o
);
  localparam int LOW_W = ADDR_W - SECT_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  wcls_t             cls;
  mode_e             mode;
  rsel_e             rsel;
  logic [SECT_W-1:0] susp_sect;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  nbc_decode #(.LOW_W(LOW_W)) i_decode (
    .lo_addr_i (wr_addr_i[LOW_W-1:0]),
    .data_i    (wr_data_i),
    .cls_o     (cls)
  );

  nbc_fsm #(.SECT_W(SECT_W)) i_fsm (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .wr_en_i       (wr_en_i),
    .cls_i         (cls),
    .wr_sect_i     (wr_addr_i[ADDR_W-1:LOW_W]),
    .alg_done_i    (alg_done_i),
    .alg_fail_i    (alg_fail_i),
    .mode_o        (mode),
    .sect_o        (susp_sect),
    .prog_start_o  (prog_start_o),
    .erase_start_o (erase_start_o)
  );

  nbc_rdsel #(.SECT_W(SECT_W)) i_rdsel (
    .mode_i      (mode),
    .rd_sect_i   (rd_sect_i),
    .susp_sect_i (susp_sect),
    .sel_o       (rsel)
  );

  assign mode_o      = mode;
  assign rd_sel_o    = rsel;
  assign fail_flag_o = (mode == M_FAULT);
endmodule

// File: rtl/nbc_bank_ctrl_chk.sv
module nbc_bank_ctrl_chk
  import nbc_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic       alg_done_i,
  input logic       alg_fail_i,
  input logic [2:0] mode_o,
  input logic [1:0] rd_sel_o,
  input logic       prog_start_o,
  input logic       erase_start_o,
  input logic       fail_flag_o
);
  logic rst_wr, busy, quiet;
  assign rst_wr = wr_en_i && (wr_data_i == D_RESET);
  assign busy   = (mode_o == M_PROG) || (mode_o == M_ERASE) || (mode_o == M_SPROG);
  assign quiet  = !alg_done_i && !alg_fail_i;

  p_prog_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |-> (mode_o == M_PROG || mode_o == M_SPROG));

  p_prog_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |=> !prog_start_o);

  p_erase_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |-> (mode_o == M_ERASE));

  p_busy_reset_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rst_wr && quiet) |=> (mode_o == $past(mode_o)));

  p_id_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_AUTOSEL) |-> (rd_sel_o == RS_ID));

  p_suspend_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_ERASE && wr_en_i && wr_data_i == D_SUSPEND && quiet) |=> (mode_o == M_SUSP));

  p_done_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_PROG && alg_done_i && !alg_fail_i) |=> (mode_o == M_READ));

  p_fault_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag_o |-> (rd_sel_o == RS_STATUS));

  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_FAULT && !rst_wr) |=> (mode_o == M_FAULT));

  p_lock_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == M_LOCK && !rst_wr) |=> (mode_o == M_LOCK));
endmodule

bind nbc_bank_ctrl nbc_bank_ctrl_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .alg_done_i    (alg_done_i),
  .alg_fail_i    (alg_fail_i),
  .mode_o        (mode_o),
  .rd_sel_o      (rd_sel_o),
  .prog_start_o  (prog_start_o),
  .erase_start_o (erase_start_o),
  .fail_flag_o   (fail_flag_o)
);

// File: tb/test_nbc_bank_ctrl.sv
module test_nbc_bank_ctrl;
  localparam int ADDR_W = 16;
  localparam int SECT_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = '0;
  logic [SECT_W-1:0] rd_sect = '0;
  logic              alg_done = 1'b0;
  logic              alg_fail = 1'b0;
  logic [2:0]        mode;
  logic [1:0]        rd_sel;
  logic              prog_start, erase_start, fail_flag;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  nbc_bank_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) i_nbc_bank_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en_i       (wr_en),
    .wr_addr_i     (wr_addr),
    .wr_data_i     (wr_data),
    .rd_sect_i     (rd_sect),
    .alg_done_i    (alg_done),
    .alg_fail_i    (alg_fail),
    .mode_o        (mode),
    .rd_sel_o      (rd_sel),
    .prog_start_o  (prog_start),
    .erase_start_o (erase_start),
    .fail_flag_o   (fail_flag)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(16'h0555, 8'hAA);
    wr(16'h02AA, 8'h55);
  endtask

  task automatic pulse_done();
    @(negedge clk); alg_done = 1'b1;
    @(negedge clk); alg_done = 1'b0;
  endtask

  task automatic pulse_fail();
    @(negedge clk); alg_fail = 1'b1;
    @(negedge clk); alg_fail = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 0);
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 fail_flag", fail_flag, 0);
    chk("R1 starts", {prog_start, erase_start}, 0);
  endtask

  task automatic t_program();
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h3123, 8'h5A);
    chk("R2 prog_start", prog_start, 1);
    chk("R2 mode", mode, 2);
    @(negedge clk);
    chk("R2 pulse one cycle", prog_start, 0);
    chk("R12 busy status", rd_sel, 1);
    wr(16'h0000, 8'hF0);
    chk("R5 reset ignored in program", mode, 2);
    pulse_done();
    chk("R9 program done", mode, 0);
    chk("R12 array after done", rd_sel, 0);
  endtask

  task automatic t_abort();
    unlock();
    wr(16'h0555, 8'h80);
    wr(16'h7ABC, 8'hF0);
    chk("R4 erase abort mode", mode, 0);
    chk("R4 no erase start", erase_start, 0);
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h1111, 8'hF0);
    chk("R4 program abort mode", mode, 0);
    chk("R4 no program start", prog_start, 0);
    wr(16'h0123, 8'h77);
    chk("R11 stray write ignored", mode, 0);
  endtask

  task automatic t_autoselect();
    unlock();
    wr(16'h0555, 8'h90);
    chk("R6 autosel mode", mode, 1);
    chk("R6 id select", rd_sel, 2);
    unlock();
    chk("R6 unlock ignored", mode, 1);
    wr(16'h0000, 8'hF0);
    chk("R6 exit to read", mode, 0);
  endtask

  task automatic t_erase_suspend();
    unlock();
    wr(16'h0555, 8'h80);
    unlock();
    wr(16'h5004, 8'h30);
    chk("R3 erase_start", erase_start, 1);
    chk("R3 mode", mode, 3);
    @(negedge clk);
    chk("R3 pulse one cycle", erase_start, 0);
    wr(16'h0000, 8'hF0);
    chk("R5 reset ignored in erase", mode, 3);
    wr(16'h0000, 8'hB0);
    chk("R7 suspended", mode, 4);
    rd_sect = 4'd5;
    #1 chk("R7 suspended sector status", rd_sel, 1);
    rd_sect = 4'd2;
    #1 chk("R7 other sector array", rd_sel, 0);
    unlock();
    wr(16'h0555, 8'h90);
    chk("R6 autosel from suspend", mode, 1);
    wr(16'h0000, 8'hF0);
    chk("R6 return to suspend", mode, 4);
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h2010, 8'h11);
    chk("R8 prog start in suspend", prog_start, 1);
    chk("R8 mode", mode, 5);
    wr(16'h0000, 8'hF0);
    chk("R5 reset ignored in suspend program", mode, 5);
    pulse_done();
    chk("R8 back to suspend", mode, 4);
    rd_sect = 4'd5;
    #1 chk("R8 suspended sector still status", rd_sel, 1);
    unlock();
    wr(16'h0000, 8'hF0);
    chk("R4 abort keeps suspend", mode, 4);
    wr(16'h0000, 8'h30);
    chk("R7 resume", mode, 3);
    pulse_done();
    chk("R9 erase done", mode, 0);
  endtask

  task automatic t_fail();
    unlock();
    wr(16'h0555, 8'hA0);
    wr(16'h4000, 8'h00);
    pulse_fail();
    chk("R10 fault mode", mode, 6);
    chk("R10 fail flag", fail_flag, 1);
    chk("R10 status select", rd_sel, 1);
    wr(16'h0555, 8'hAA);
    chk("R10 holds", mode, 6);
    wr(16'h0000, 8'hF0);
    chk("R10 cleared", mode, 0);
    chk("R10 flag cleared", fail_flag, 0);
  endtask

  task automatic t_lockout();
    wr(16'h0555, 8'hAA);
    wr(16'h0555, 8'h55);
    chk("R11 lockout", mode, 7);
    chk("R11 status select", rd_sel, 1);
    unlock();
    wr(16'h0555, 8'hA0);
    chk("R11 holds", mode, 7);
    wr(16'h0000, 8'hF0);
    chk("R11 cleared", mode, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_program();
    t_abort();
    t_autoselect();
    t_erase_suspend();
    t_fail();
    t_lockout();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule